// File: doc/BRIEF.md
# SDRAM Self Refresh Sequencer

This block takes an SDRAM out of normal service into self refresh for low-power data retention and brings it back afterwards. A sleep request from the memory controller makes it drive the refresh command with the clock enable pulled low in the same cycle. It then keeps the clock enable low for a minimum residency before it will act on a wake request.

On wake, it waits for the system to report a stable clock. It then raises the clock enable and issues a run of NOP cycles so the device can finish any internal refresh. Finally it hands the command bus back with a one-cycle done flag and a one-cycle pulse telling the refresh scheduler that catch-up refreshes must be issued before normal traffic. Precharging the banks beforehand and gating the clock are the caller's concern.

Top module: `srefresh_seq`

## Requirements
- R1: After reset the clock enable is high, the command is NOP (`{cs_n,ras_n,cas_n,we_n}` = 4'b0111), and sleep_ack, wake_ack, done, refresh_catchup and seq_active are all low.
- R2: A sleep_req sampled high while idle makes the next cycle the entry cycle. In that cycle the command is refresh (4'b0001), the clock enable is low and sleep_ack is high. sleep_ack is high in that one cycle only per sleep.
- R3: Counting the entry cycle, the clock enable stays low for at least T_RAS consecutive cycles.
- R4: While the clock enable is low, every cycle after the entry cycle carries the NOP command. A sleep_req raised during this time is ignored and produces no sleep_ack.
- R5: A wake_req arriving at any time from the entry cycle onward is remembered until the residency has run out. wake_ack is high for exactly one cycle, the cycle the wake is taken in the sleep state. The clock enable rises no sooner than two cycles after that cycle.
- R6: The clock enable rises only in the cycle after clk_stable was sampled high while waiting. If clk_stable stays low, the clock enable stays low.
- R7: Once the clock enable is high again, exactly max(T_XSR, 2) cycles of NOP pass before done.
- R8: done and refresh_catchup are high together for one cycle right after the NOP run. In the following cycle the block is idle again, with seq_active low.
- R9: A wake_req given while idle is ignored and is not remembered for a later sleep.
- R10: seq_active is high from the entry cycle through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter self refresh |
| sleep_ack | output | 1 | High in the entry cycle |
| wake_req | input | 1 | Request to leave self refresh |
| wake_ack | output | 1 | High in the cycle the wake is taken |
| clk_stable | input | 1 | Clock reported stable by the system |
| cke | output | 1 | SDRAM clock enable |
| cmd | output | 4 | SDRAM command {cs_n,ras_n,cas_n,we_n} |
| seq_active | output | 1 | Sequencer owns the command bus |
| refresh_catchup | output | 1 | One-cycle pulse: catch-up refreshes needed |
| done | output | 1 | One-cycle pulse: exit finished |

## Verification
A wrong state or count shows first on the clock enable. It rises too early or too late relative to the entry cycle, or relative to clk_stable, and this is visible within the same sleep episode. A miscounted exit run shows as a wrong number of high clock-enable cycles before done. A lost or stray wake latch shows as a shifted rise of the clock enable in the next episode. The bench compares each episode's low and high run lengths against values worked out from the wake and clock-stable timing.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_HOLD_MIN,
        ST_SLEEP,
        ST_WAIT_CLK,
        ST_EXIT_NOP,
        ST_DONE
    } srs_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    typedef struct packed {
        logic     cke;
        sdr_cmd_t cmd;
        logic     sleep_ack;
        logic     wake_ack;
        logic     done;
        logic     catchup;
        logic     active;
    } srs_out_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srs_dwell_cnt.sv
module srs_dwell_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/srs_fsm.sv
module srs_fsm
    import srs_pkg::*;
#(
    parameter int unsigned W         = 4,
    parameter int unsigned HOLD_LOAD = 1,
    parameter int unsigned NOP_LOAD  = 1
) (
    input  srs_state_e   state,
    input  logic         sleep_req,
    input  logic         wake_seen,
    input  logic         clk_stable,
    input  logic         cnt_zero,
    output srs_state_e   nxt,
    output logic         load,
    output logic [W-1:0] load_val
);
    localparam logic [W-1:0] HOLD_V = W'(HOLD_LOAD);
    localparam logic [W-1:0] NOP_V  = W'(NOP_LOAD);

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        unique case (state)
            ST_IDLE:     if (sleep_req) nxt = ST_ENTER;
            ST_ENTER: begin
                nxt      = ST_HOLD_MIN;
                load     = 1'b1;
                load_val = HOLD_V;
            end
            ST_HOLD_MIN: if (cnt_zero) nxt = ST_SLEEP;
            ST_SLEEP:    if (wake_seen) nxt = ST_WAIT_CLK;
            ST_WAIT_CLK: begin
                if (clk_stable) begin
                    nxt      = ST_EXIT_NOP;
                    load     = 1'b1;
                    load_val = NOP_V;
                end
            end
            ST_EXIT_NOP: if (cnt_zero) nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/srs_outdec.sv
module srs_outdec
    import srs_pkg::*;
(
    input  srs_state_e state,
    input  logic       wake_seen,
    output srs_out_t   o
);
    always_comb begin
        o           = '0;
        o.cke       = 1'b1;
        o.cmd       = CMD_NOP;
        o.active    = (state != ST_IDLE);
        unique case (state)
            ST_ENTER: begin
                o.cke       = 1'b0;
                o.cmd       = CMD_REF;
                o.sleep_ack = 1'b1;
            end
            ST_HOLD_MIN, ST_WAIT_CLK: o.cke = 1'b0;
            ST_SLEEP: begin
                o.cke      = 1'b0;
                o.wake_ack = wake_seen;
            end
            ST_DONE: begin
                o.done    = 1'b1;
                o.catchup = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/srefresh_seq.sv
module srefresh_seq
    import srs_pkg::*;
#(
    parameter int unsigned T_RAS = 7,
    parameter int unsigned T_XSR = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    output logic       sleep_ack,
    input  logic       wake_req,
    output logic       wake_ack,
    input  logic       clk_stable,
    output logic       cke,
    output logic [3:0] cmd,
    output logic       seq_active,
    output logic       refresh_catchup,
    output logic       done
);
    localparam int unsigned NOP_CYC = max_u(T_XSR, 2);
    localparam int unsigned MAXC    = max_u(T_RAS, NOP_CYC);
    localparam int unsigned CW      = $clog2(MAXC + 1);

    srs_state_e    state, nxt;
    logic          wake_pend, wake_seen;
    logic          load, cnt_zero;
    logic [CW-1:0] load_val;
    srs_out_t      o;

    assign wake_seen = wake_req | wake_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            wake_pend <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_ENTER || state == ST_HOLD_MIN)
                wake_pend <= wake_seen;
            else
                wake_pend <= 1'b0;
        end
    end

    srs_fsm #(
        .W(CW), .HOLD_LOAD(T_RAS - 2), .NOP_LOAD(NOP_CYC - 1)
    ) u_fsm (
        .state(state), .sleep_req(sleep_req), .wake_seen(wake_seen),
        .clk_stable(clk_stable), .cnt_zero(cnt_zero),
        .nxt(nxt), .load(load), .load_val(load_val)
    );

    srs_dwell_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero(cnt_zero)
    );

    srs_outdec u_dec (.state(state), .wake_seen(wake_seen), .o(o));

    assign cke             = o.cke;
    assign cmd             = o.cmd;
    assign sleep_ack       = o.sleep_ack;
    assign wake_ack        = o.wake_ack;
    assign done            = o.done;
    assign refresh_catchup = o.catchup;
    assign seq_active      = o.active;
endmodule

// File: rtl/srefresh_seq_chk.sv
module srefresh_seq_chk #(
    parameter int unsigned T_RAS = 7,
    parameter int unsigned T_XSR = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       sleep_req,
    input logic       sleep_ack,
    input logic       clk_stable,
    input logic       cke,
    input logic [3:0] cmd,
    input logic       refresh_catchup,
    input logic       done
);
    localparam int unsigned NOP_CYC = (T_XSR > 2) ? T_XSR : 2;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_REF = 4'b0001;

    logic [15:0] lo_run, hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run <= '0;
            hi_run <= '0;
        end else begin
            lo_run <= cke  ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
            hi_run <= !cke ? '0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1);
        end
    end

    assert_entry_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_REF) |-> (!cke && sleep_ack));
    assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |-> $past(sleep_req));
    assert_min_dwell_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (lo_run >= T_RAS));
    assert_nop_while_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!cke && !sleep_ack) |-> (cmd == C_NOP));
    assert_stable_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> $past(clk_stable));
    assert_exit_len_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (hi_run == NOP_CYC));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> refresh_catchup);
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        refresh_catchup |=> !refresh_catchup);
endmodule

bind srefresh_seq srefresh_seq_chk #(.T_RAS(T_RAS), .T_XSR(T_XSR)) u_chk (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_ack(sleep_ack),
    .clk_stable(clk_stable), .cke(cke), .cmd(cmd),
    .refresh_catchup(refresh_catchup), .done(done)
);

// File: tb/test_srefresh_seq.sv
module test_srefresh_seq;
    localparam int T_RAS   = 5;
    localparam int T_XSR   = 1;
    localparam int NOP_CYC = (T_XSR > 2) ? T_XSR : 2;
    localparam int NV      = 8;
    // stimulus: wake pulse cycle and clk_stable rise cycle, relative to entry
    localparam int VW [NV] = '{0, 2, 4, 8, 5, 12, 6, 1};
    localparam int VC [NV] = '{0, 0, 9, 0, 5, 20, 14, 30};

    logic       clk = 1'b0, rst = 1'b1;
    logic       sleep_req = 0, wake_req = 0, clk_stable = 0;
    logic       sleep_ack, wake_ack, cke, seq_active, refresh_catchup, done;
    logic [3:0] cmd;
    int total = 0, bad = 0, cyc = 0;

    always #4 clk = ~clk;

    srefresh_seq #(.T_RAS(T_RAS), .T_XSR(T_XSR)) i_srefresh_seq (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_ack(sleep_ack),
        .wake_req(wake_req), .wake_ack(wake_ack), .clk_stable(clk_stable),
        .cke(cke), .cmd(cmd), .seq_active(seq_active),
        .refresh_catchup(refresh_catchup), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_check(input string tag);
        chk(cke === 1'b1 && cmd === 4'b0111, {tag, " cke/cmd idle"}, {cke, cmd}, 5'b10111);
        chk({sleep_ack, wake_ack, done, refresh_catchup, seq_active} === 5'b0,
            {tag, " flags idle"}, {sleep_ack, wake_ack, done, refresh_catchup, seq_active}, 0);
    endtask

    task automatic run_vec(input int w, input int c);
        int lo = 0, hi = 0, sa = 0, wa = 0, cu = 0, badcmd = 0, ign = 0, inact = 0;
        int s, exp_lo;
        bit fin = 0;
        s      = (w > T_RAS) ? w : T_RAS;
        exp_lo = (((s + 1) > c) ? (s + 1) : c) + 1;
        @(negedge clk);
        sleep_req = 1; wake_req = 0; clk_stable = 0;
        #1;
        for (int i = 0; i < 400 && !fin; i++) begin
            @(negedge clk);
            sleep_req  = (i == 2);
            wake_req   = (i == w);
            clk_stable = (i >= c);
            #1;
            if (i == 0)
                chk(cmd === 4'b0001 && cke === 1'b0 && sleep_ack === 1'b1,
                    "R2 entry cycle", {cmd, cke, sleep_ack}, 6'b000101);
            if (!cke) lo++;
            if (i > 0 && !cke && cmd !== 4'b0111) badcmd++;
            if (i == 2 && sleep_ack) ign++;
            if (!seq_active) inact++;
            if (sleep_ack) sa++;
            if (wake_ack) wa++;
            if (refresh_catchup) cu++;
            if (cke && !done) hi++;
            if (done) fin = 1;
        end
        chk(fin, "R8 done reached", fin, 1);
        chk(sa == 1, "R2 sleep_ack count", sa, 1);
        chk(lo >= T_RAS, "R3 min dwell", lo, T_RAS);
        chk(badcmd == 0 && ign == 0, "R4 NOP while low / sleep ignored", badcmd + ign, 0);
        chk(lo == exp_lo, "R5/R6 cke low length", lo, exp_lo);
        chk(wa == 1, "R5 wake_ack count", wa, 1);
        chk(hi == NOP_CYC, "R7 exit NOP cycles", hi, NOP_CYC);
        chk(cu == 1, "R8 catchup pulse", cu, 1);
        chk(inact == 0, "R10 active during sequence", inact, 0);
        @(negedge clk);
        sleep_req = 0; wake_req = 0; clk_stable = 0;
        #1;
        idle_check("R8 after done");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        idle_check("R1 reset");
        // vector table
        for (int v = 0; v < NV; v++) run_vec(VW[v], VC[v]);
        // R9: wake in idle is ignored and not remembered
        @(negedge clk); wake_req = 1; #1;
        @(negedge clk); wake_req = 0; #1;
        idle_check("R9 wake in idle");
        run_vec(30, 0);
        // R6: clk_stable held off for a long time
        run_vec(T_RAS, 60);
        // reset in the middle of a sleep returns to idle
        @(negedge clk); sleep_req = 1;
        @(negedge clk); sleep_req = 0;
        repeat (3) @(negedge clk);
        rst = 1;
        @(negedge clk); rst = 0; #1;
        idle_check("R1 reset mid-sleep");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule